// File: doc/BRIEF.md
# Interrupt cause and mask controller

This block gathers up to 29 peripheral interrupt requests into a 32-bit cause word. It gates that word with a 32-bit enable mask and raises a single interrupt line towards the CPU. Each source sets its own cause bit, and the bit holds until software clears it. Three positions of the cause word are not sources: they read back as OR summaries of fixed groups of source bits, so a handler can tell from one read which part of the word needs attention.

Software reaches the two registers through a plain register port. Writes take effect at the next clock edge, and reads return the current contents combinationally. Software acknowledges a source by writing a 0 to its cause bit. Alongside the interrupt line the block presents the index of the lowest-numbered pending, enabled source together with a valid flag. An acknowledge strobe that arrives while no such source exists counts as spurious, and a saturating counter records these events.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause and mask registers read as zero, `irq_o` and `vec_valid_o` are low and `spur_cnt_o` is zero.
- R2: `src_i[k]` high at a rising clock edge sets cause bit k+1 (bits 1 to 29), and the bit stays set after the input drops until software clears it.
- R3: A write to the cause register (`reg_addr_i` = 0) clears every source bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When a source is high in the same cycle that software writes 0 to its cause bit, the bit remains set.
- R5: On a cause read, bit 0 is the OR of source bits 29:1, bit 30 is the OR of source bits 29:26 and 20:1, and bit 31 is the OR of source bits 25:1, all taken from the unmasked cause bits.
- R6: Cause bits 0, 30 and 31 ignore the values written to them.
- R7: A write with `reg_addr_i` = 1 loads all 32 bits of the mask register, and a read with `reg_addr_i` = 1 returns them.
- R8: One clock edge after the cause and mask registers change, `irq_o` is high exactly when some bit in 29:1 is set in both registers.
- R9: `vec_valid_o` follows `irq_o`, and `vec_o` holds the lowest bit index in 29:1 that is set in both registers, with the same one-edge delay.
- R10: `ack_i` high at a clock edge while `vec_valid_o` is low increments `spur_cnt_o` by one and saturates at 65535; `ack_i` while `vec_valid_o` is high leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 29 | Interrupt sources; bit k feeds cause bit k+1 |
| reg_addr_i | input | 1 | Register select: 0 cause, 1 mask |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| ack_i | input | 1 | CPU acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | `vec_o` holds a pending enabled source |
| vec_o | output | 5 | Index of the highest-priority pending source |
| spur_cnt_o | output | 16 | Saturating count of spurious acknowledges |

## Verification
A source or register write takes effect at one clock edge and shows on `reg_rdata_o` straight after it. `irq_o`, `vec_valid_o` and `vec_o` change at the following edge, and `spur_cnt_o` changes at the edge that samples `ack_i`. The bench drives every input on the falling edge and reads cause and mask half a cycle after the changing edge. It waits one further falling edge before it checks the interrupt line or the vector, so each check samples the output in the exact cycle its result is due. The summary groups, the set-over-clear collision and counter saturation each have their own directed scenario.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W  = 32;
    localparam int NSRC    = 29;
    localparam int SRC_LO  = 1;
    localparam int SUM_ALL = 0;
    localparam int SUM_GA  = 30;
    localparam int SUM_GB  = 31;
    localparam int VEC_W   = $clog2(DATA_W);

    // source positions and the two irregular summary groups
    localparam logic [DATA_W-1:0] SRC_BITS = 32'h3FFF_FFFE;
    localparam logic [DATA_W-1:0] GRP_A    = 32'h3C1F_FFFE;
    localparam logic [DATA_W-1:0] GRP_B    = 32'h03FF_FFFE;

    typedef enum logic {
        SEL_CAUSE = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_vec_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cause_o
);
    typedef struct packed {
        logic [W-1:0] cause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.cause = st_q.cause & wdata_i;
        end
        // a new request beats a simultaneous clear
        st_d.cause = (st_d.cause | set_vec_i) & KEEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;

    a_r2_set_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_vec_i) |=> ((st_q.cause & $past(set_vec_i & KEEP)) == $past(set_vec_i & KEEP)));

    a_r3_clear_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ((st_q.cause & ~$past(wdata_i) & ~$past(set_vec_i)) == '0));

    a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> ((st_q.cause & ~$past(st_q.cause) & ~$past(set_vec_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W  = 32,
    parameter int LO = 1,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  pend_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        // scan downward so the lowest index is the last to win
        for (int i = W - 1; i >= LO; i--) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_spur_cnt.sv
module irq_spur_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ack_i,
    input  logic             valid_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i && !valid_i && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    a_r10_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

    a_r10_quiet_when_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i || !ack_i) |=> $stable(st_q.cnt));

    a_r10_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !valid_i && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_agg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ack_i,
    output logic              irq_o,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [CNT_W-1:0]  spur_cnt_o
);
    localparam int PAD_W = DATA_W - NSRC - SRC_LO;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              irq;
        logic              vld;
        logic [VEC_W-1:0]  vec;
    } st_t;

    st_t st_d, st_q;

    reg_sel_e          sel;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] cause_raw;
    logic [DATA_W-1:0] pend_vec;
    logic [DATA_W-1:0] cause_view;
    logic              enc_vld;
    logic [VEC_W-1:0]  enc_idx;
    logic              cause_we;

    assign sel      = reg_sel_e'(reg_addr_i);
    assign set_vec  = {{PAD_W{1'b0}}, src_i, {SRC_LO{1'b0}}};
    assign cause_we = reg_we_i && (sel == SEL_CAUSE);

    irq_cause_reg #(
        .W    (DATA_W),
        .KEEP (SRC_BITS)
    ) u_cause (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_vec_i (set_vec),
        .wr_en_i   (cause_we),
        .wdata_i   (reg_wdata_i),
        .cause_o   (cause_raw)
    );

    assign pend_vec = cause_raw & st_q.mask & SRC_BITS;

    irq_prio_enc #(
        .W  (DATA_W),
        .LO (SRC_LO)
    ) u_enc (
        .pend_i  (pend_vec),
        .valid_o (enc_vld),
        .idx_o   (enc_idx)
    );

    // summary positions are rebuilt from the unmasked cause on every read
    always_comb begin
        cause_view          = cause_raw & SRC_BITS;
        cause_view[SUM_ALL] = |(cause_raw & SRC_BITS);
        cause_view[SUM_GA]  = |(cause_raw & GRP_A);
        cause_view[SUM_GB]  = |(cause_raw & GRP_B);
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |pend_vec;
        st_d.vld = enc_vld;
        st_d.vec = enc_idx;
        if (reg_we_i && sel == SEL_MASK) begin
            st_d.mask = reg_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o = (sel == SEL_MASK) ? st_q.mask : cause_view;
    assign irq_o       = st_q.irq;
    assign vec_valid_o = st_q.vld;
    assign vec_o       = st_q.vec;

    irq_spur_cnt #(
        .CNT_W (CNT_W)
    ) u_spur (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ack_i   (ack_i),
        .valid_i (st_q.vld),
        .cnt_o   (spur_cnt_o)
    );

    a_r8_irq_tracks_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(cause_raw & st_q.mask & SRC_BITS)));

    a_r9_valid_equals_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o == irq_o);

    a_r9_vec_was_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> (((($past(pend_vec)) >> vec_o) & 32'd1) != 32'd0));

    a_r9_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> (vec_o >= VEC_W'(SRC_LO) && vec_o <= VEC_W'(NSRC)));

    a_r7_mask_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && sel == SEL_MASK) |=> (st_q.mask == $past(reg_wdata_i)));
endmodule

// File: tb/irq_cause_ctrl_bench.sv
module irq_cause_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] src = '0;
    logic        addr = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic        irq;
    logic        vld;
    logic [4:0]  vec;
    logic [15:0] cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_cause_ctrl u_irq_cause_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ack_i       (ack),
        .irq_o       (irq),
        .vec_valid_o (vld),
        .vec_o       (vec),
        .spur_cnt_o  (cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        addr = sel; we = 1'b1; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        addr = sel;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input int b);
        src = '0;
        src[b-1] = 1'b1;
        tick();
        src = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(1'b0, d); check("R1 cause", d, 0);
        rd(1'b1, d); check("R1 mask", d, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 valid", 32'(vld), 0);
        check("R1 count", 32'(cnt), 0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(5);
        rd(1'b0, d); check("R2 R5 latch bit5", d, 32'hC000_0021);
        tick(); tick();
        rd(1'b0, d); check("R2 held after drop", d, 32'hC000_0021);
        check("R8 masked no irq", 32'(irq), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); check("R7 mask readback", d, 32'hFFFF_FFFF);
        tick();
        check("R8 irq raised", 32'(irq), 1);
        check("R9 valid", 32'(vld), 1);
        check("R9 vector 5", 32'(vec), 5);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(1'b0, ~(32'd1 << 5));
        rd(1'b0, d); check("R3 cleared", d, 0);
        tick();
        check("R8 irq dropped", 32'(irq), 0);
        pulse(12);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R3 write one keeps", d, 32'hC000_1001);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_groups();
        logic [31:0] d;
        pulse(22);
        rd(1'b0, d); check("R5 bit22 groups", d, 32'h8040_0001);
        wr(1'b0, 0);
        pulse(27);
        rd(1'b0, d); check("R5 bit27 groups", d, 32'h4800_0001);
        wr(1'b0, 0);
        pulse(26);
        rd(1'b0, d); check("R5 bit26 groups", d, 32'h4400_0001);
        wr(1'b0, 0);
    endtask

    task automatic t_summary_ro();
        logic [31:0] d;
        pulse(3);
        wr(1'b0, 32'h3FFF_FFFE);
        rd(1'b0, d); check("R6 summary ignores write", d, 32'hC000_0009);
        wr(1'b1, 32'h0);
        rd(1'b0, d); check("R5 unmasked summary", d, 32'hC000_0009);
        tick();
        check("R8 irq off with mask 0", 32'(irq), 0);
    endtask

    task automatic t_priority();
        wr(1'b1, 32'hFFFF_FFFF);
        pulse(9);
        tick();
        check("R9 lowest wins", 32'(vec), 3);
        wr(1'b0, ~(32'd1 << 3));
        tick();
        check("R9 next source", 32'(vec), 9);
        wr(1'b1, ~(32'd1 << 9));
        tick();
        check("R9 valid off when masked", 32'(vld), 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        src = '0; src[13] = 1'b1;
        addr = 1'b0; we = 1'b1; wdata = 32'h0;
        tick();
        src = '0; we = 1'b0;
        rd(1'b0, d); check("R4 set beats clear", d, 32'hC000_4001);
        wr(1'b0, 0);
    endtask

    task automatic t_spurious();
        wr(1'b1, 32'hFFFF_FFFF);
        tick();
        ack = 1'b1; tick(); ack = 1'b0;
        check("R10 spurious counted", 32'(cnt), 1);
        pulse(2);
        tick();
        ack = 1'b1; tick(); ack = 1'b0;
        check("R10 valid ack not counted", 32'(cnt), 1);
        wr(1'b0, 0);
        tick();
        ack = 1'b1;
        repeat (65540) tick();
        ack = 1'b0;
        check("R10 saturates", 32'(cnt), 32'hFFFF);
        ack = 1'b1; tick(); ack = 1'b0;
        check("R10 stays at max", 32'(cnt), 32'hFFFF);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latch();
        t_mask();
        t_clear();
        t_groups();
        t_summary_ro();
        t_priority();
        t_collide();
        t_spurious();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule